// File: doc/BRIEF.md
# Rippling Down-Counter with Binary Load

This block is an N-bit down-counter whose every bit is a small cell holding one of three digits: ZERO (this bit is 0 and some higher bit is 1), ONE (this bit is 1), or NIL (this bit and every bit above it are 0). Because the least significant cell alone knows whether the whole value is zero, the zero flag comes straight from one register, however wide the counter is.

A command enters at the least significant cell and climbs one cell per clock. A decrement stops climbing at the first cell that held ONE. A load always climbs to the top, and each cell takes its own digit as the command passes. A binary-to-digit converter turns the load word into digits at the port. It scans from the most significant bit down, carrying a flag that says every higher bit is clear, so a cleared bit under a clear upper part becomes NIL. Each cell holds at most one command. A cell acts on that command only once the cell above it is empty, so commands never overtake one another. The port then accepts one command every two cycles, whatever the width.

Top module: `dwn_load_counter`

## Requirements
- R1: Leaving reset, `zero_o` is 1 and `cmd_ready` is 1 (the stored value is 0).
- R2: A load (`cmd_op`=1) of the word 0 makes `zero_o` 1 in the second cycle after the accepting edge.
- R3: A load of any non-zero word makes `zero_o` 0 in the second cycle after the accepting edge.
- R4: After a load of value v (1 to 2^N-1), `zero_o` stays 0 through the first v-1 decrements and is 1 after the v-th.
- R5: A decrement (`cmd_op`=0) accepted while the value is 0 wraps it to 2^N-1. `zero_o` then reads 0, and exactly 2^N-1 further decrements return it to 1.
- R6: A command is accepted on an edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 in the cycle after every acceptance and 1 again in the cycle after that, so back-to-back commands go through every second cycle.
- R7: `zero_o` can change only in the second cycle after an acceptance. Whenever `cmd_ready` is 1, it equals (value == 0), where the value includes every command accepted so far.
- R8: A decrement accepted immediately after a load acts on the loaded value, in every bit.
- R9: A load accepted while earlier decrements are still climbing the cells replaces the whole value; those decrements leave no trace in it.
- R10: `cmd_data` is ignored on a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Lowest cell is free to accept a command |
| cmd_op | input | 1 | 0 = decrement, 1 = load |
| cmd_data | input | WIDTH | Binary word for a load |
| zero_o | output | 1 | Stored value is zero |

## Verification
Two things can be in motion at once: a new command entering the lowest cell, and an older command, or a load's digits, still climbing through the upper cells. The bench provokes this by issuing decrements and loads at the full one-in-two-cycle rate, including a load right behind decrements and a decrement right behind a load. In those runs the lowest cell must read the upper cells' zero status while the upper cells are still busy. A behavioural integer model of the value is updated at every accepting edge. The handshake and the zero flag are compared against that model on every clock, and after each burst the bench counts the decrements needed to reach zero.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  // Per-bit digit held by each cell
  typedef enum logic [1:0] {
    DG_ZERO = 2'b00,  // bit is 0, some higher bit is 1
    DG_ONE  = 2'b01,  // bit is 1
    DG_NIL  = 2'b10   // bit and all higher bits are 0
  } digit_t;

  typedef enum logic {
    OP_DEC  = 1'b0,
    OP_LOAD = 1'b1
  } op_t;
endpackage

// File: rtl/dlc_loader.sv
module dlc_loader
  import dlc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]      word_i,
  output logic [WIDTH-1:0][1:0] dig_o
);
  // clr_above[b] : every bit at position >= b is clear
  logic [WIDTH:1] clr_above;
  assign clr_above[WIDTH] = 1'b1;

  for (genvar b = WIDTH - 1; b >= 0; b--) begin : g_bit
    if (b > 0) begin : g_flag
      assign clr_above[b] = clr_above[b+1] & ~word_i[b];
    end
    assign dig_o[b] = word_i[b]       ? DG_ONE :
                      clr_above[b+1]  ? DG_NIL : DG_ZERO;
  end
endmodule

// File: rtl/dlc_cell.sv
module dlc_cell
  import dlc_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDX   = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  push_i,
  input  logic                  push_op_i,
  input  logic [WIDTH-1:0][1:0] push_dig_i,
  input  logic                  up_busy_i,
  input  logic                  up_nil_i,
  output logic                  busy_o,
  output logic                  fwd_o,
  output logic                  fwd_op_o,
  output logic [WIDTH-1:0][1:0] fwd_dig_o,
  output logic                  nil_o
);
  logic                  full_q;
  op_t                   op_q;
  logic [WIDTH-1:0][1:0] dig_q;
  digit_t                st_q, st_d;
  logic                  go, fwd;

  // act only when the cell above has settled
  assign go = full_q & ~up_busy_i;

  always_comb begin
    st_d = st_q;
    fwd  = 1'b0;
    if (go) begin
      if (op_q == OP_LOAD) begin
        st_d = digit_t'(dig_q[IDX]);
        fwd  = 1'b1;
      end else if (st_q == DG_ONE) begin
        st_d = up_nil_i ? DG_NIL : DG_ZERO;
      end else begin
        st_d = DG_ONE;
        fwd  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      op_q   <= OP_DEC;
      dig_q  <= '0;
      st_q   <= DG_NIL;
    end else begin
      if (push_i) begin
        full_q <= 1'b1;
        op_q   <= op_t'(push_op_i);
        dig_q  <= push_dig_i;
      end else if (go) begin
        full_q <= 1'b0;
      end
      st_q <= st_d;
    end
  end

  assign busy_o    = full_q;
  assign fwd_o     = fwd;
  assign fwd_op_o  = op_q;
  assign fwd_dig_o = dig_q;
  assign nil_o     = (st_q == DG_NIL);
endmodule

// File: rtl/dwn_load_counter.sv
module dwn_load_counter
  import dlc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_op,
  input  logic [WIDTH-1:0] cmd_data,
  output logic             zero_o
);
  logic [WIDTH-1:0][1:0]         conv;
  logic [WIDTH:0]                push, push_op, busy, nil;
  logic [WIDTH:0][WIDTH-1:0][1:0] pdig;

  dlc_loader #(.WIDTH(WIDTH)) u_load (
    .word_i (cmd_data),
    .dig_o  (conv)
  );

  assign push[0]     = cmd_valid & cmd_ready;
  assign push_op[0]  = cmd_op;
  assign pdig[0]     = conv;
  assign busy[WIDTH] = 1'b0;   // above the top: always idle
  assign nil[WIDTH]  = 1'b1;   // above the top: always zero

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    dlc_cell #(.WIDTH(WIDTH), .IDX(i)) u_cell (
      .clk        (clk),
      .rst        (rst),
      .push_i     (push[i]),
      .push_op_i  (push_op[i]),
      .push_dig_i (pdig[i]),
      .up_busy_i  (busy[i+1]),
      .up_nil_i   (nil[i+1]),
      .busy_o     (busy[i]),
      .fwd_o      (push[i+1]),
      .fwd_op_o   (push_op[i+1]),
      .fwd_dig_o  (pdig[i+1]),
      .nil_o      (nil[i])
    );
  end

  // commands leaving the top cell are dropped
  logic unused_cap;
  assign unused_cap = ^{push[WIDTH], push_op[WIDTH], pdig[WIDTH]};

  assign cmd_ready = ~busy[0];
  assign zero_o    = nil[0];
endmodule

// File: rtl/dlc_chk.sv
module dlc_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_op,
  input logic [WIDTH-1:0] cmd_data,
  input logic             zero_o
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (zero_o && cmd_ready));

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> !cmd_ready);

  // R6
  ready_back_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> ##1 cmd_ready);

  // R2
  load_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op && cmd_data == '0) |=> ##1 zero_o);

  // R3
  load_nz_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op && cmd_data != '0) |=> ##1 !zero_o);

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !cmd_op && zero_o) |=> ##1 !zero_o);

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> ##1 $stable(zero_o));
endmodule

bind dwn_load_counter dlc_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dwn_load_counter_tb.sv
`timescale 1ns/1ps
module dwn_load_counter_tb;
  localparam int W   = 5;
  localparam int LIM = 1 << (W + 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic         cmd_op = 1'b0;
  logic [W-1:0] cmd_data = '0;
  logic         cmd_ready, zero_o;

  int tests = 0, fails = 0, cyc = 0;
  logic [W-1:0] model = '0, mprev = '0;
  logic         acc_d = 1'b0;
  logic         mon_on = 1'b0;

  always #2 clk = ~clk;

  dwn_load_counter #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .zero_o(zero_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference value, updated at every accepting edge
  always @(posedge clk) begin
    if (rst) begin
      model <= '0; mprev <= '0; acc_d <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        mprev <= model;
        model <= cmd_op ? cmd_data : model - 1'b1;  // R10: data unused on decrement
      end
      acc_d <= cmd_valid && cmd_ready;
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      check(cmd_ready == !acc_d, "R6 ready", cmd_ready, !acc_d);
      check(zero_o == (acc_d ? (mprev == 0) : (model == 0)), "R7 zero",
            zero_o, acc_d ? (mprev == 0) : (model == 0));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic issue(input logic op, input logic [W-1:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_data = W'($urandom);
  endtask

  // decrement until zero shows, compare the count
  task automatic drain(input int exp, input string tag);
    int n = 0;
    @(negedge clk);
    while (!zero_o && n < LIM) begin
      issue(1'b0, W'($urandom));
      @(negedge clk);
      n++;
    end
    check(n == exp, tag, n, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(zero_o == 1'b1, "R1 zero", zero_o, 1);
    check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    mon_on = 1'b1;

    // R2: load zero after nonzero
    issue(1'b1, W'(9));
    issue(1'b1, '0);
    @(negedge clk);
    check(zero_o == 1'b1, "R2", zero_o, 1);

    // R3 and R4 with value 1
    issue(1'b1, W'(1));
    @(negedge clk);
    check(zero_o == 1'b0, "R3", zero_o, 0);
    drain(1, "R4 v=1");

    // R4 with top bit only
    issue(1'b1, W'(1 << (W - 1)));
    drain(1 << (W - 1), "R4 v=msb");

    // R5 wrap from zero
    issue(1'b0, '0);
    @(negedge clk);
    check(zero_o == 1'b0, "R5 wrapped", zero_o, 0);
    drain((1 << W) - 1, "R5 count");

    // R4 all ones
    issue(1'b1, '1);
    drain((1 << W) - 1, "R4 v=max");

    // R4 random values
    for (int k = 0; k < 6; k++) begin
      int v;
      v = 1 + ($urandom % ((1 << W) - 1));
      issue(1'b1, W'(v));
      drain(v, "R4 random");
    end

    // R8: decrements right behind a load
    issue(1'b1, W'(6));
    issue(1'b0, '1);
    issue(1'b0, '1);
    drain(4, "R8");

    // R9: load behind climbing decrements
    issue(1'b1, W'(16));
    issue(1'b0, '0);
    issue(1'b0, '0);
    issue(1'b1, W'(3));
    drain(3, "R9");

    // R10: data on decrement ignored
    issue(1'b1, W'(2));
    issue(1'b0, '0);
    @(negedge clk);
    check(zero_o == 1'b0, "R10", zero_o, 0);
    drain(1, "R10 count");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule